// File: doc/BRIEF.md
# One-time-programmable memory mode sequencer

This block is the control front end of a one-time-programmable memory macro. Software writes an 8-bit mode and configuration word over a simple register bus. The low three bits pick an operating mode. The upper bits choose which cell arrays a program pulse reaches, whether margin reads use high-temperature thresholds, and whether the main area or the test row is addressed. The block turns the stored word into registered control lines for the macro: regulator enable, array select, program, margin read, high-temperature margin, test-row select, and one enable per array (normal and redundancy).

Each accepted mode change starts a settling interval. A programmable counter models this interval. While it runs, the mode-ready status output is low and the register refuses writes. The option bits can change only while the macro is in one of its two inactive modes. Because of this, a changed option takes effect on the next entry into the mode that uses it. The bulk-copy mode stays not-ready until an external copy-complete pulse arrives. On that pulse the block drops back to deep standby by itself and raises ready in the same cycle.

Top module: `otp_mode_seq`

## Requirements
- R1: A synchronous reset clears the stored word to 0x00 (deep standby, all options clear). After reset `mode_ready` is 1 and every macro control output is 0.
- R2: `reg_rdata` returns the stored word at all times, with this layout: bits 2:0 are the mode, bit 3 always reads 0, bit 4 is the test-row option, bit 5 is the high-temperature option, and bits 7:6 are the program-array select. A write's effect is visible in the cycle after the clock edge that samples `reg_wr`.
- R3: The mode codes are 0 deep standby, 1 standby, 2 read, 3 program, 4 post-program margin verify, 5 initial margin check and 6 bulk copy. `ldo_en` is high in every mode except 0. `mem_sel` is high in modes 2 to 6.
- R4: When `mode_ready` is 1 and the current mode is 0 or 1, a write updates bits 7:4 (subject to R9), whether or not its mode field changes.
- R5: A write accepted with a legal mode code different from the current one, other than bulk copy, holds `mode_ready` low for exactly SETTLE_CYCLES cycles, starting with the cycle after the write. Writing the current mode code again starts no transition.
- R6: While `mode_ready` is 0, a register write has no effect on any field.
- R7: When the current mode is 2 to 6, the option bits of a write are ignored. The mode field of the same write still acts.
- R8: `margin_en` is high only in modes 4 and 5. `hot_margin` is high only when `margin_en` is high and bit 5 is set. Bit 5 has no effect in read mode.
- R9: A mode code of 7 leaves the mode unchanged and starts no transition. A program-array select of 3 leaves the previous select in place. Bit 3 is never stored.
- R10: `prog_en` is high only in mode 3. In that mode select 0 drives both `prog_norm` and `prog_red`, select 1 drives only `prog_norm`, and select 2 drives only `prog_red`. Outside mode 3 both are low.
- R11: After entering bulk copy, `mode_ready` stays low until `copy_done` is sampled high after the settling count has elapsed. At that edge the mode becomes 0 and `mode_ready` becomes 1 together. `copy_done` in any other situation is ignored.
- R12: `test_row` is high only in modes 2 to 6 while bit 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Stored mode and configuration word |
| copy_done | input | 1 | Bulk copy completion pulse |
| mode_ready | output | 1 | High when the current mode is usable |
| ldo_en | output | 1 | Macro internal regulator enable |
| mem_sel | output | 1 | Macro select |
| prog_en | output | 1 | Program operation enable |
| prog_norm | output | 1 | Program pulse reaches the normal array |
| prog_red | output | 1 | Program pulse reaches the redundancy array |
| margin_en | output | 1 | Margin read enable |
| hot_margin | output | 1 | High-temperature margin thresholds |
| test_row | output | 1 | Address the test row instead of the main area |

## Verification
The bench measures the not-ready window cycle by cycle. A counter that is off by one shows up as ready rising one cycle early or late. It also writes during a transition, and a design that only locked the mode field would show the option bits changing. It offers option changes in active modes and the reserved codes 7 and 3, where a filter that was too loose would corrupt the read-back word. In bulk copy it sends a completion pulse during settling and another one in read mode: a design that honoured either one would return to deep standby too early or leave its mode.

// File: rtl/otp_mode_pkg.sv
package otp_mode_pkg;

  localparam int WORD_W  = 8;
  localparam int MODE_W  = 3;
  localparam int ASEL_W  = 2;

  localparam int TROW_BIT = 4;
  localparam int HOT_BIT  = 5;
  localparam int ASEL_LSB = 6;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF     = 3'd0,
    MODE_IDLE    = 3'd1,
    MODE_READ    = 3'd2,
    MODE_PROG    = 3'd3,
    MODE_VERIFY  = 3'd4,
    MODE_INITCHK = 3'd5,
    MODE_BULK    = 3'd6
  } mode_e;

  localparam logic [MODE_W-1:0] MODE_BAD = 3'd7;
  localparam logic [ASEL_W-1:0] ASEL_BAD = 2'd3;

  typedef struct packed {
    logic [ASEL_W-1:0] arr_sel;
    logic              hot;
    logic              trow;
  } cfg_t;

  typedef struct packed {
    logic ldo;
    logic msel;
    logic prog;
    logic norm;
    logic red;
    logic margin;
    logic hot;
    logic trow;
  } pins_t;

endpackage

// File: rtl/otp_cfg_regs.sv
module otp_cfg_regs
  import otp_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ready,
  input  logic              bulk_done,
  output mode_e             mode_q,
  output cfg_t              cfg_q,
  output mode_e             mode_d,
  output cfg_t              cfg_d,
  output logic              mode_start,
  output logic              bulk_start
);

  logic              wr_ok;
  logic [MODE_W-1:0] mode_wr;
  logic              mode_legal;
  logic              cfg_open;
  logic [ASEL_W-1:0] asel_wr;

  assign wr_ok      = wr_en && ready;
  assign mode_wr    = wdata[MODE_W-1:0];
  assign asel_wr    = wdata[ASEL_LSB +: ASEL_W];
  assign mode_legal = (mode_wr != MODE_BAD);
  assign mode_start = wr_ok && mode_legal && (mode_wr != mode_q);
  assign bulk_start = mode_start && (mode_wr == MODE_BULK);
  assign cfg_open   = wr_ok && ((mode_q == MODE_OFF) || (mode_q == MODE_IDLE));

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_open) begin
      cfg_d.hot  = wdata[HOT_BIT];
      cfg_d.trow = wdata[TROW_BIT];
      if (asel_wr != ASEL_BAD) cfg_d.arr_sel = asel_wr;
    end
  end

  always_comb begin
    mode_d = mode_q;
    if (bulk_done)       mode_d = MODE_OFF;
    else if (mode_start) mode_d = mode_e'(mode_wr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_OFF;
      cfg_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cfg_q  <= cfg_d;
    end
  end

  // R9: the stored mode never holds the reserved code
  a_r9_no_bad_mode: assert property (@(posedge clk) disable iff (rst)
    mode_q != MODE_BAD);

  // R9: the stored array select never holds the reserved code
  a_r9_no_bad_asel: assert property (@(posedge clk) disable iff (rst)
    cfg_q.arr_sel != ASEL_BAD);

  // R7: options are frozen while an active mode is current
  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_OFF && mode_q != MODE_IDLE) |=> $stable(cfg_q));

  // R6: no write lands while not ready (only the bulk return moves the mode)
  a_r6_locked: assert property (@(posedge clk) disable iff (rst)
    (!ready && !bulk_done) |=> ($stable(mode_q) && $stable(cfg_q)));

endmodule

// File: rtl/otp_settle_timer.sv
module otp_settle_timer #(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_bulk,
  input  logic copy_done,
  output logic ready,
  output logic bulk_done
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wait_q, wait_d;
  logic             ready_q;

  assign bulk_done = wait_q && (cnt_q == '0) && copy_done;

  always_comb begin
    cnt_d  = cnt_q;
    wait_d = wait_q;
    if (start) begin
      cnt_d  = CNT_LOAD;
      wait_d = start_bulk;
    end else begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      if (bulk_done)   wait_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      wait_q  <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      wait_q  <= wait_d;
      ready_q <= (cnt_d == '0) && !wait_d;
    end
  end

  assign ready = ready_q;

  // R5: the count never exceeds its load value
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LOAD);

  // R5: an accepted change drops ready on the next cycle
  a_r5_drop: assert property (@(posedge clk) disable iff (rst)
    start |=> !ready);

  // R11: bulk wait holds ready low until completion is taken
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (wait_q && !copy_done) |=> !ready);

  // R11: taking completion releases ready at once
  a_r11_release: assert property (@(posedge clk) disable iff (rst)
    bulk_done |=> ready);

endmodule

// File: rtl/otp_pin_decode.sv
module otp_pin_decode
  import otp_mode_pkg::*;
(
  input  mode_e mode,
  input  cfg_t  cfg,
  output pins_t pins
);

  logic active, prog, margin;

  assign active = (mode != MODE_OFF) && (mode != MODE_IDLE);
  assign prog   = (mode == MODE_PROG);
  assign margin = (mode == MODE_VERIFY) || (mode == MODE_INITCHK);

  always_comb begin
    pins        = '0;
    pins.ldo    = (mode != MODE_OFF);
    pins.msel   = active;
    pins.prog   = prog;
    pins.norm   = prog && (cfg.arr_sel == 2'd0 || cfg.arr_sel == 2'd1);
    pins.red    = prog && (cfg.arr_sel == 2'd0 || cfg.arr_sel == 2'd2);
    pins.margin = margin;
    pins.hot    = margin && cfg.hot;
    pins.trow   = active && cfg.trow;
  end

endmodule

// File: rtl/otp_mode_seq.sv
module otp_mode_seq
  import otp_mode_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       copy_done,
  output logic       mode_ready,
  output logic       ldo_en,
  output logic       mem_sel,
  output logic       prog_en,
  output logic       prog_norm,
  output logic       prog_red,
  output logic       margin_en,
  output logic       hot_margin,
  output logic       test_row
);

  mode_e mode_q, mode_d;
  cfg_t  cfg_q, cfg_d;
  logic  mode_start, bulk_start, bulk_done, ready;
  pins_t pins_d, pins_q;

  otp_cfg_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr),
    .wdata      (reg_wdata),
    .ready      (ready),
    .bulk_done  (bulk_done),
    .mode_q     (mode_q),
    .cfg_q      (cfg_q),
    .mode_d     (mode_d),
    .cfg_d      (cfg_d),
    .mode_start (mode_start),
    .bulk_start (bulk_start)
  );

  otp_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .start      (mode_start),
    .start_bulk (bulk_start),
    .copy_done  (copy_done),
    .ready      (ready),
    .bulk_done  (bulk_done)
  );

  otp_pin_decode u_dec (
    .mode (mode_d),
    .cfg  (cfg_d),
    .pins (pins_d)
  );

  always_ff @(posedge clk) begin
    if (rst) pins_q <= '0;
    else     pins_q <= pins_d;
  end

  assign reg_rdata  = {cfg_q.arr_sel, cfg_q.hot, cfg_q.trow, 1'b0, mode_q};
  assign mode_ready = ready;
  assign ldo_en     = pins_q.ldo;
  assign mem_sel    = pins_q.msel;
  assign prog_en    = pins_q.prog;
  assign prog_norm  = pins_q.norm;
  assign prog_red   = pins_q.red;
  assign margin_en  = pins_q.margin;
  assign hot_margin = pins_q.hot;
  assign test_row   = pins_q.trow;

  // R3: the macro is never selected with its regulator off
  a_r3_sel_needs_ldo: assert property (@(posedge clk) disable iff (rst)
    mem_sel |-> ldo_en);

  // R10: a program operation always reaches at least one array
  a_r10_prog_arr: assert property (@(posedge clk) disable iff (rst)
    prog_en |-> (prog_norm || prog_red));

  // R8: high-temperature thresholds only ride on a margin read
  a_r8_hot_in_margin: assert property (@(posedge clk) disable iff (rst)
    hot_margin |-> margin_en);

  // R11: leaving bulk copy lands in deep standby with ready high
  a_r11_return: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) == MODE_BULK && mode_q != MODE_BULK) |-> (mode_q == MODE_OFF && mode_ready));

endmodule

// File: tb/otp_mode_seq_test.sv
`timescale 1ns/1ps
module otp_mode_seq_test;

  localparam int SETTLE = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       copy_done = 1'b0;
  logic       mode_ready;
  logic       ldo_en, mem_sel, prog_en, prog_norm, prog_red;
  logic       margin_en, hot_margin, test_row;

  otp_mode_seq #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .copy_done(copy_done), .mode_ready(mode_ready),
    .ldo_en(ldo_en), .mem_sel(mem_sel), .prog_en(prog_en),
    .prog_norm(prog_norm), .prog_red(prog_red), .margin_en(margin_en),
    .hot_margin(hot_margin), .test_row(test_row)
  );

  always #2 clk = ~clk;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic       rdy;
    logic [7:0] pins;
  } exp_t;

  exp_t q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // Expected macro pins from the stored word, per R3, R8, R10, R12
  function automatic logic [7:0] pins_for(input logic [7:0] w);
    logic [2:0] m;
    logic [1:0] s;
    logic act, pr, mg;
    m   = w[2:0];
    s   = w[7:6];
    act = (m >= 3'd2) && (m <= 3'd6);
    pr  = (m == 3'd3);
    mg  = (m == 3'd4) || (m == 3'd5);
    return {m != 3'd0, act, pr, pr && (s != 2'd2), pr && (s != 2'd1),
            mg, mg && w[5], act && w[4]};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr    = 1'b1;
    reg_wdata = d;
    tick();
    reg_wr    = 1'b0;
  endtask

  task automatic expect_st(input string tag, input logic [7:0] rd, input logic rdy);
    exp_t e;
    e.tag  = tag;
    e.rd   = rd;
    e.rdy  = rdy;
    e.pins = pins_for(rd);
    q.push_back(e);
  endtask

  task automatic settle();
    repeat (SETTLE) tick();
  endtask

  // Monitor: compares the queued expectations half a cycle later
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      logic [7:0] act_pins;
      e = q.pop_front();
      act_pins = {ldo_en, mem_sel, prog_en, prog_norm, prog_red,
                  margin_en, hot_margin, test_row};
      n_run++;
      if (reg_rdata !== e.rd || mode_ready !== e.rdy || act_pins !== e.pins) begin
        n_fail++;
        $display("FAIL %s: rdata=%h ready=%b pins=%b, expected rdata=%h ready=%b pins=%b",
                 e.tag, reg_rdata, mode_ready, act_pins, e.rd, e.rdy, e.pins);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    expect_st("R1 reset state", 8'h00, 1'b1);
    tick();

    // R2 R4: options written in deep standby, no mode change
    wr(8'hB0);
    expect_st("R2 R4 options in deep standby", 8'hB0, 1'b1);
    tick();

    // R3 R5: change to standby, exact not-ready window
    wr(8'hB1);
    expect_st("R3 R5 standby entry, ready low cycle 1", 8'hB1, 1'b0);
    wr(8'h02);
    expect_st("R6 write during transition ignored", 8'hB1, 1'b0);
    tick();
    expect_st("R5 ready low cycle 3", 8'hB1, 1'b0);
    tick();
    expect_st("R5 ready low cycle 4", 8'hB1, 1'b0);
    tick();
    expect_st("R5 ready returns after SETTLE cycles", 8'hB1, 1'b1);

    // R8 R12: read mode, hot bit has no effect, test row shown
    wr(8'hB2);
    expect_st("R8 R12 read mode outputs", 8'hB2, 1'b0);
    settle();
    wr(8'h0A);
    expect_st("R7 R9 options and bit3 ignored in read mode", 8'hB2, 1'b1);
    tick();
    expect_st("R5 same mode write starts no transition", 8'hB2, 1'b1);

    // R8: margin verify with hot thresholds
    wr(8'h04);
    expect_st("R7 R8 margin verify, options kept", 8'hB4, 1'b0);
    settle();
    wr(8'hB7);
    expect_st("R9 mode code 7 ignored", 8'hB4, 1'b1);
    tick();
    expect_st("R9 no transition after code 7", 8'hB4, 1'b1);
    wr(8'h05);
    expect_st("R8 initial margin check", 8'hB5, 1'b0);
    settle();
    wr(8'h01);
    expect_st("R7 back to standby, options kept", 8'hB1, 1'b0);
    settle();
    wr(8'hC1);
    expect_st("R9 select 3 keeps previous select", 8'h81, 1'b1);
    tick();

    // R10: program array selection
    wr(8'h43);
    expect_st("R10 program normal only", 8'h43, 1'b0);
    settle();
    wr(8'h81);
    expect_st("R7 select ignored in program mode", 8'h41, 1'b0);
    settle();
    wr(8'h83);
    expect_st("R10 program redundancy only", 8'h83, 1'b0);
    settle();
    wr(8'h01);
    settle();
    wr(8'h03);
    expect_st("R10 program both arrays", 8'h03, 1'b0);
    settle();

    // R11: completion pulse outside bulk copy ignored
    wr(8'h02);
    settle();
    copy_done = 1'b1;
    tick();
    copy_done = 1'b0;
    expect_st("R11 copy_done ignored in read mode", 8'h02, 1'b1);
    wr(8'h00);
    settle();

    // R11: bulk copy
    wr(8'h16);
    expect_st("R11 R12 bulk copy entry", 8'h16, 1'b0);
    copy_done = 1'b1;
    tick();
    copy_done = 1'b0;
    expect_st("R11 early copy_done ignored", 8'h16, 1'b0);
    repeat (6) tick();
    expect_st("R11 ready held low awaiting completion", 8'h16, 1'b0);
    copy_done = 1'b1;
    tick();
    copy_done = 1'b0;
    expect_st("R11 return to deep standby with ready", 8'h10, 1'b1);
    tick();

    // R1: reset in the middle of a transition
    wr(8'h11);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    expect_st("R1 reset during transition", 8'h00, 1'b1);
    tick();
    tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule